// File: doc/BRIEF.md
# Wide-to-byte bus sizing bridge

The bridge connects a 32-bit host access port to an 8-bit peripheral register bus. A host request carries a size (byte, halfword or word), a byte address, a direction and, for writes, a 32-bit data word. The bridge breaks the request into one, two or four byte cycles on the peripheral side. Byte cycles go out lowest byte first, to ascending byte addresses. Writes steer one data lane per beat. Reads gather the returned bytes back into a word.

Every peripheral byte cycle lasts a fixed number of clocks, set by `BEAT_CYC` (default 2, minimum 2). During a read, the read strobe stays high for the whole multi-beat span. This suits peripherals whose read data path is purely combinational. During a write, the write strobe is pulsed once per beat. A peripheral that decodes several byte addresses to one register therefore keeps only the byte written last.

While a sequence runs, the bridge accepts no new request. Completion is signalled by a single-cycle done pulse.

Top module: `bus_sizer`

## Requirements
- R1: A word request (size code 2, or the unused code 3) produces four byte cycles. Their addresses are the word-aligned base plus 0, 1, 2 and 3, in that order.
- R2: A byte request (size code 0) produces exactly one byte cycle, at the requested address.
- R3: A halfword request (size code 1) produces two byte cycles: first the even address, then the next odd address.
- R4: During a read, `prd_o` is high in every cycle of every beat, with no gap between beats. It is low once the sequence ends.
- R5: In each write beat, `pwr_o` is high for the first `BEAT_CYC`-1 clocks and low for the last clock. `pwr_o` and `prd_o` are never high together. During beat n, `pwdata_o` carries host bits [8n+7:8n], and both it and `paddr_o` stay stable while the strobe is high.
- R6: On a read, the byte present on `prdata_i` in the last clock of beat n lands in bits [8n+7:8n] of `rdata_o`. Bits of lanes that were not read are zero. `rdata_o` is cleared when a request is accepted.
- R7: `done_o` is high for exactly one clock, right after the last beat. A request with k beats therefore gives accept edge, then k*`BEAT_CYC` busy clocks, then one done clock.
- R8: `ready_o` is high only when the bridge is idle. A request that is held or changed while the bridge is busy or signalling done has no effect on the running sequence.
- R9: While `rst_ni` is low, the bridge is idle: `ready_o` is 1 and `prd_o`, `pwr_o` and `done_o` are 0.
- R10: A word write of 0x12345678 to a register that aliases all four byte addresses leaves 0x12 in that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, taken when ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| addr_i | input | AW | Host byte address |
| wdata_i | input | 32 | Host write data |
| ready_o | output | 1 | Bridge idle |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 32 | Gathered read word |
| paddr_o | output | AW | Peripheral byte address |
| prd_o | output | 1 | Peripheral read strobe |
| pwr_o | output | 1 | Peripheral write strobe |
| pwdata_o | output | 8 | Peripheral write byte |
| prdata_i | input | 8 | Peripheral read byte |

## Verification
The assertions assume two things about the inputs. First, `BEAT_CYC` is at least 2. Second, the base address plus the beat count does not wrap the address space, so each new write pulse lands exactly one address above the previous one. The stimulus only uses addresses from 0 to 0x13. While the bridge is busy, it keeps `req_i` high with unrelated values, which exercises the rule that a busy bridge ignores requests. The peripheral model behind the bridge answers reads combinationally from the current address, and it folds 0x10 to 0x13 onto one register.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } state_e;

  localparam int unsigned NLANE = 4;
  localparam int unsigned LW    = $clog2(NLANE);
endpackage

// File: rtl/bsz_seq.sv
module bsz_seq
  import bsz_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter int unsigned BEAT_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] addr_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          ready_o,
  output logic          write_o,
  output logic          beat_end_o,
  output logic [LW-1:0] beat_o,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned CW = (BEAT_CYC > 2) ? $clog2(BEAT_CYC) : 1;

  state_e        state_q;
  logic [CW-1:0] cyc_q;
  logic [LW-1:0] beat_q, last_q;
  logic [AW-1:0] base_q;
  logic          we_q;
  size_e         size;

  assign size       = size_e'(size_i);
  assign accept_o   = (state_q == ST_IDLE) && req_i;
  assign busy_o     = (state_q == ST_BUSY);
  assign done_o     = (state_q == ST_DONE);
  assign ready_o    = (state_q == ST_IDLE);
  assign write_o    = we_q;
  assign beat_end_o = busy_o && (cyc_q == CW'(BEAT_CYC - 1));
  assign beat_o     = beat_q;
  assign addr_o     = base_q + AW'(beat_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
      beat_q  <= '0;
      last_q  <= '0;
      base_q  <= '0;
      we_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_BUSY;
          cyc_q   <= '0;
          beat_q  <= '0;
          we_q    <= we_i;
          unique case (size)
            SZ_BYTE: begin
              last_q <= LW'(0);
              base_q <= addr_i;
            end
            SZ_HALF: begin
              last_q <= LW'(1);
              base_q <= {addr_i[AW-1:1], 1'b0};
            end
            default: begin
              last_q <= LW'(NLANE - 1);
              base_q <= {addr_i[AW-1:2], 2'b00};
            end
          endcase
        end
        ST_BUSY: begin
          if (beat_end_o) begin
            cyc_q <= '0;
            if (beat_q == last_q) state_q <= ST_DONE;
            else                  beat_q  <= beat_q + LW'(1);
          end else begin
            cyc_q <= cyc_q + CW'(1);
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_beat_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (beat_q <= last_q));
  assert_done_after_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
endmodule

// File: rtl/bsz_lane.sv
module bsz_lane
  import bsz_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [31:0]   wdata_i,
  input  logic [LW-1:0] beat_i,
  output logic [7:0]    byte_o
);
  logic [7:0] lane_q [NLANE];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     lane_q[g] <= '0;
      else if (load_i) lane_q[g] <= wdata_i[8*g +: 8];
    end
  end

  assign byte_o = lane_q[beat_i];
endmodule

// File: rtl/bsz_gather.sv
module bsz_gather
  import bsz_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          cap_i,
  input  logic [LW-1:0] beat_i,
  input  logic [7:0]    byte_i,
  output logic [31:0]   word_o
);
  for (genvar g = 0; g < NLANE; g++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           word_o[8*g +: 8] <= '0;
      else if (clear_i)                      word_o[8*g +: 8] <= '0;
      else if (cap_i && beat_i == LW'(g))    word_o[8*g +: 8] <= byte_i;
    end
  end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bsz_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter int unsigned BEAT_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [31:0]   rdata_o,
  output logic [AW-1:0] paddr_o,
  output logic          prd_o,
  output logic          pwr_o,
  output logic [7:0]    pwdata_o,
  input  logic [7:0]    prdata_i
);
  logic          accept, busy, write, beat_end;
  logic [LW-1:0] beat;

  bsz_seq #(.AW(AW), .BEAT_CYC(BEAT_CYC)) u_seq (
    .clk_i, .rst_ni, .req_i, .we_i, .size_i, .addr_i,
    .accept_o(accept), .busy_o(busy), .done_o(done_o), .ready_o(ready_o),
    .write_o(write), .beat_end_o(beat_end), .beat_o(beat), .addr_o(paddr_o)
  );

  bsz_lane u_lane (
    .clk_i, .rst_ni, .load_i(accept), .wdata_i, .beat_i(beat), .byte_o(pwdata_o)
  );

  bsz_gather u_gather (
    .clk_i, .rst_ni, .clear_i(accept), .cap_i(beat_end && !write),
    .beat_i(beat), .byte_i(prdata_i), .word_o(rdata_o)
  );

  // read strobe spans all beats; write strobe drops in the last clock of each beat
  assign prd_o = busy && !write;
  assign pwr_o = busy && write && !beat_end;

  assert_rd_fall_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prd_o) |-> done_o);
  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prd_o && pwr_o));
  assert_wr_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_o |=> (!pwr_o || ($stable(paddr_o) && $stable(pwdata_o))));
  assert_addr_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pwr_o) && !$past(ready_o)) |-> (paddr_o == $past(paddr_o) + AW'(1)));
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ready_o));
  assert_busy_not_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prd_o || pwr_o) |-> !ready_o);
endmodule

// File: tb/bus_sizer_bench.sv
module bus_sizer_bench;
  localparam int unsigned AW = 8;
  localparam int unsigned BC = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [1:0]    size = '0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          ready, done, prd, pwr;
  logic [31:0]   rdata;
  logic [AW-1:0] paddr;
  logic [7:0]    pwdata, prdata;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  bus_sizer #(.AW(AW), .BEAT_CYC(BC)) u_bus_sizer (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .ready_o(ready), .done_o(done),
    .rdata_o(rdata), .paddr_o(paddr), .prd_o(prd), .pwr_o(pwr),
    .pwdata_o(pwdata), .prdata_i(prdata)
  );

  // peripheral: 16 plain bytes at 0x00-0x0f, one aliased register at 0x10-0x1f
  logic [7:0] mem [16];
  logic [7:0] alias_q;
  assign prdata = paddr[4] ? alias_q : mem[paddr[3:0]];
  always @(posedge clk) if (pwr) begin
    if (paddr[4]) alias_q <= pwdata;
    else          mem[paddr[3:0]] <= pwdata;
  end

  // independent shadow of the peripheral
  logic [7:0] sh [16];
  logic [7:0] sh_alias;

  function automatic logic [7:0] sh_rd(logic [7:0] a);
    return a[4] ? sh_alias : sh[a[3:0]];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic access(bit w, logic [1:0] sz, logic [7:0] a, logic [31:0] wd, bit junk);
    int nb;
    logic [7:0] base;
    logic [31:0] exp_rd;
    string atag;
    nb     = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    base   = (sz == 2'd0) ? a : (sz == 2'd1) ? {a[7:1], 1'b0} : {a[7:2], 2'b00};
    atag   = (nb == 1) ? "R2 addr" : (nb == 2) ? "R3 addr" : "R1 addr";
    exp_rd = '0;
    for (int b = 0; b < nb; b++) exp_rd[8*b +: 8] = sh_rd(base + 8'(b));
    @(negedge clk);
    chk("R8 ready idle", ready, 1);
    req = 1; we = w; size = sz; addr = a; wdata = wd;
    @(negedge clk);
    if (junk) begin
      we = ~w; size = 2'd0; addr = 8'h0c; wdata = 32'hdeadbeef;
    end else req = 0;
    for (int b = 0; b < nb; b++) begin
      for (int c = 0; c < BC; c++) begin
        chk(atag, paddr, base + 8'(b));
        chk("R4 prd", prd, !w);
        chk("R5 pwr", pwr, w && (c < BC - 1));
        if (w) chk("R5 lane", pwdata, wd[8*b +: 8]);
        chk("R7 done low", done, 0);
        chk("R8 ready busy", ready, 0);
        @(negedge clk);
      end
    end
    chk("R7 done", done, 1);
    chk("R4 prd off", prd, 0);
    chk("R5 pwr off", pwr, 0);
    chk("R8 ready done", ready, 0);
    if (!w) chk("R6 rdata", rdata, exp_rd);
    req = 0;
    if (w) for (int b = 0; b < nb; b++) begin
      logic [7:0] ad;
      ad = base + 8'(b);
      if (ad[4]) sh_alias = wd[8*b +: 8];
      else       sh[ad[3:0]] = wd[8*b +: 8];
    end
    @(negedge clk);
    chk("R7 done one clock", done, 0);
    chk("R8 ready back", ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'(i * 17 + 3);
      sh[i]  = 8'(i * 17 + 3);
    end
    alias_q = 8'h5a; sh_alias = 8'h5a;
    repeat (3) @(negedge clk);
    chk("R9 ready", ready, 1);
    chk("R9 prd", prd, 0);
    chk("R9 pwr", pwr, 0);
    chk("R9 done", done, 0);
    rst_ni = 1;
    access(0, 2'd2, 8'h04, 0, 0);             // R1 word read
    access(1, 2'd2, 8'h07, 32'ha1b2c3d4, 0);  // R1 unaligned word write aligns down
    access(0, 2'd3, 8'h04, 0, 0);             // R1 reserved code behaves as word
    access(0, 2'd0, 8'h09, 0, 0);             // R2 byte read, R6 upper lanes zero
    access(1, 2'd0, 8'h0b, 32'hffffff77, 0);  // R2 byte write uses lane 0
    access(0, 2'd1, 8'h03, 0, 0);             // R3 half read at 2,3
    access(1, 2'd1, 8'h0e, 32'h00009988, 1);  // R3 half write, R8 junk request held
    access(0, 2'd2, 8'h0c, 0, 1);             // R6 read back, R8 junk during read
    access(1, 2'd2, 8'h10, 32'h12345678, 0);  // R10 aliased word write
    chk("R10 alias holds last", alias_q, 8'h12);
    access(0, 2'd0, 8'h12, 0, 0);             // R10 read alias via bridge
    access(0, 2'd2, 8'h10, 0, 0);             // R4 continuous read across aliased beats
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule